// File: doc/BRIEF.md
# Headphone Pop-Free Power-Up Sequencer

This block brings one headphone output channel from off to carrying signal without an audible click. When the power request goes high, it first holds the driver in a slow-charge phase. The length of that phase is a programmable number of RC time constants, picked from a nonlinear table. During this phase the output coupling capacitor settles to the common-mode level, and no signal reaches the driver.

Once charging ends, the signal route opens at the highest attenuation, 72 dB. The attenuation then falls by 1 dB at a time, with a programmable millisecond interval between steps, until it reaches the requested level. At that point a completion flag goes high. From then on, changes to the target attenuation take effect on the next cycle. Dropping the power request returns the channel to its off state in any phase.

The charge length is counted in eighths of a time constant. A free-running tick input, `tc8_tick`, pulses once per eighth. A second tick input, `ms_tick`, pulses once per millisecond and paces the gain steps. Configuration is accepted only while the channel is off.

Top module: `hp_popfree_seq`

## Requirements
- R1: After reset, `chg_en`, `route_en`, `done` and `cfg_err` are 0 and `att` is 72. The stored configuration after reset is charge code 4'b0101, resistor code 2'b00 and step code 2'b01.
- R2: The charge phase counts down a length given in eighth-time-constant ticks by the charge code. The mapping is: 0→0, 1→4, 2→5, 3→6, 4→7, 5→8, 6→16, 7→24, 8→32, 9→40, 10→48, 11→56, 12→64, 13→128, 14→192, 15→256. With a non-zero length, exactly that many `tc8_tick` pulses are seen while `chg_en` is high. A zero length holds `chg_en` high for one cycle.
- R3: `chg_en` and `route_en` are never high together, so no signal is routed while charging.
- R4: When resistor code 2'b10 (the large resistor) or 2'b11 is written with charge code 13, 14 or 15, the stored length is clamped to 64 eighths (8 time constants). A sticky `cfg_err` also sets, and only reset clears it.
- R5: Step code 2'b00 disables the ramp: the route opens and `att` reaches the target in a single ramp cycle. Step codes 01, 10 and 11 give one attenuation step every STEP_MS, 2×STEP_MS and 4×STEP_MS `ms_tick` pulses.
- R6: The ramp starts at 72 and changes by at most 1 dB per cycle, never upward. It ends exactly at the target, with targets above 72 treated as 72. A ramp from 72 to target T uses (72−T)×interval `ms_tick` pulses.
- R7: `done` rises when the ramp reaches the target. While `done` is high, `att` equals the clamped target of the previous cycle.
- R8: Configuration writes made while the channel is not off are ignored.
- R9: One cycle after `pwr_req` is low, `chg_en`, `route_en` and `done` are 0 and `att` is 72, whatever the phase.
- R10: `done` high implies `route_en` high and `chg_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Power request, level sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_res | input | 2 | Charge resistor code |
| cfg_tc_code | input | 4 | Charge length code |
| cfg_step_code | input | 2 | Soft-step interval code |
| tgt_att | input | ATT_W | Target attenuation in dB |
| ms_tick | input | 1 | One pulse per millisecond |
| tc8_tick | input | 1 | One pulse per eighth of a time constant |
| chg_en | output | 1 | Slow-charge enable |
| route_en | output | 1 | Signal route enable |
| att | output | ATT_W | Current attenuation in dB |
| done | output | 1 | Power-up soft-stepping complete |
| cfg_err | output | 1 | Sticky invalid charge code flag |

## Verification
Several properties are checked on every cycle: charge and route never overlap, and the ramp only falls by a single dB at a time. The checks also confirm that `done` implies an open route, that a dropped power request reaches the off state one cycle later, that the error flag stays set, and that `att` tracks the target after completion. Other behaviours only show up in the bench's scenarios. These are the exact charge length per code, the clamp for invalid resistor and code pairs, the number of millisecond ticks per ramp, the ignored writes while powered, and the disabled-ramp case. The bench checks them by counting ticks across complete power-up runs.

// File: rtl/hps_pkg.sv
package hps_pkg;
  localparam int CHG_LEN_W = 9;
  localparam logic [CHG_LEN_W-1:0] CHG_CLAMP = 9'd64;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_CHARGE = 2'd1,
    ST_RAMP   = 2'd2,
    ST_DONE   = 2'd3
  } hps_state_e;

  // Charge length in eighths of a time constant
  function automatic logic [CHG_LEN_W-1:0] tc_code_eighths(input logic [3:0] code);
    logic [CHG_LEN_W-1:0] r;
    unique case (code)
      4'd0:    r = 9'd0;
      4'd1:    r = 9'd4;
      4'd2:    r = 9'd5;
      4'd3:    r = 9'd6;
      4'd4:    r = 9'd7;
      4'd5:    r = 9'd8;
      4'd6:    r = 9'd16;
      4'd7:    r = 9'd24;
      4'd8:    r = 9'd32;
      4'd9:    r = 9'd40;
      4'd10:   r = 9'd48;
      4'd11:   r = 9'd56;
      4'd12:   r = 9'd64;
      4'd13:   r = 9'd128;
      4'd14:   r = 9'd192;
      default: r = 9'd256;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/hps_cfg.sv
module hps_cfg
  import hps_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic                 lock,
  input  logic [1:0]           res_code,
  input  logic [3:0]           tc_code,
  input  logic [1:0]           step_code,
  output logic [CHG_LEN_W-1:0] len_q,
  output logic [1:0]           step_q,
  output logic                 err_q
);
  logic long_code;
  logic big_res;
  logic bad;

  assign long_code = (tc_code >= 4'd13);
  assign big_res   = (res_code >= 2'b10);
  assign bad       = long_code && big_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= tc_code_eighths(4'b0101);
      step_q <= 2'b01;
      err_q  <= 1'b0;
    end else if (we && !lock) begin
      len_q  <= bad ? CHG_CLAMP : tc_code_eighths(tc_code);
      step_q <= step_code;
      err_q  <= err_q | bad;
    end
  end
endmodule

// File: rtl/hps_charge_timer.sv
module hps_charge_timer
  import hps_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 run,
  input  logic                 tick,
  input  logic [CHG_LEN_W-1:0] len,
  output logic                 expire
);
  logic [CHG_LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= len;
    end else if (run && tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Leave on the tick that consumes the last eighth, or at once for length 0
  assign expire = run && ((cnt_q == '0) || (tick && (cnt_q == CHG_LEN_W'(1))));
endmodule

// File: rtl/hps_step_timer.sv
module hps_step_timer #(
  parameter int STEP_MS = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       ms_tick,
  input  logic [1:0] step_code,
  output logic       step_p
);
  localparam int SW = $clog2(4 * STEP_MS + 1);

  logic [SW-1:0] cnt_q;
  logic [SW-1:0] interval;
  logic          hit;

  always_comb begin
    unique case (step_code)
      2'b01:   interval = SW'(STEP_MS);
      2'b10:   interval = SW'(2 * STEP_MS);
      default: interval = SW'(4 * STEP_MS);
    endcase
  end

  assign hit    = (cnt_q == interval - SW'(1));
  assign step_p = run && ms_tick && (step_code != 2'b00) && hit;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (ms_tick) begin
      cnt_q <= hit ? '0 : cnt_q + SW'(1);
    end
  end
endmodule

// File: rtl/hp_popfree_seq.sv
module hp_popfree_seq
  import hps_pkg::*;
#(
  parameter int ATT_W   = 7,
  parameter int ATT_MAX = 72,
  parameter int STEP_MS = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_req,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_res,
  input  logic [3:0]       cfg_tc_code,
  input  logic [1:0]       cfg_step_code,
  input  logic [ATT_W-1:0] tgt_att,
  input  logic             ms_tick,
  input  logic             tc8_tick,
  output logic             chg_en,
  output logic             route_en,
  output logic [ATT_W-1:0] att,
  output logic             done,
  output logic             cfg_err
);
  localparam logic [ATT_W-1:0] ATT_TOP = ATT_W'(ATT_MAX);

  hps_state_e st_q, st_d;
  logic [CHG_LEN_W-1:0] len_q;
  logic [1:0]           step_q;
  logic                 chg_exp;
  logic                 step_p;
  logic [ATT_W-1:0]     tgt_c;
  logic [ATT_W-1:0]     att_q, att_d;
  logic                 ramp_end;

  hps_cfg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .lock     (st_q != ST_OFF),
    .res_code (cfg_res),
    .tc_code  (cfg_tc_code),
    .step_code(cfg_step_code),
    .len_q    (len_q),
    .step_q   (step_q),
    .err_q    (cfg_err)
  );

  hps_charge_timer u_chg (
    .clk   (clk),
    .rst   (rst),
    .load  (st_q != ST_CHARGE),
    .run   (st_q == ST_CHARGE),
    .tick  (tc8_tick),
    .len   (len_q),
    .expire(chg_exp)
  );

  hps_step_timer #(.STEP_MS(STEP_MS)) u_step (
    .clk      (clk),
    .rst      (rst),
    .run      (st_q == ST_RAMP),
    .ms_tick  (ms_tick),
    .step_code(step_q),
    .step_p   (step_p)
  );

  assign tgt_c = (tgt_att > ATT_TOP) ? ATT_TOP : tgt_att;

  assign ramp_end = (step_q == 2'b00) || (att_q <= tgt_c) ||
                    (step_p && ((att_q - ATT_W'(1)) <= tgt_c));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:    if (pwr_req) st_d = ST_CHARGE;
      ST_CHARGE: if (chg_exp) st_d = ST_RAMP;
      ST_RAMP:   if (ramp_end) st_d = ST_DONE;
      default:   st_d = ST_DONE;
    endcase
    if (!pwr_req) st_d = ST_OFF;
  end

  always_comb begin
    unique case (st_d)
      ST_DONE: att_d = tgt_c;
      ST_RAMP: att_d = (st_q == ST_RAMP && step_p) ? att_q - ATT_W'(1) : att_q;
      default: att_d = ATT_TOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_OFF;
      att_q    <= ATT_TOP;
      chg_en   <= 1'b0;
      route_en <= 1'b0;
      done     <= 1'b0;
    end else begin
      st_q     <= st_d;
      att_q    <= att_d;
      chg_en   <= (st_d == ST_CHARGE);
      route_en <= (st_d == ST_RAMP) || (st_d == ST_DONE);
      done     <= (st_d == ST_DONE);
    end
  end

  assign att = att_q;
endmodule

// File: rtl/hp_popfree_seq_chk.sv
module hp_popfree_seq_chk #(
  parameter int ATT_W   = 7,
  parameter int ATT_MAX = 72
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_req,
  input logic [ATT_W-1:0] tgt_att,
  input logic             chg_en,
  input logic             route_en,
  input logic [ATT_W-1:0] att,
  input logic             done,
  input logic             cfg_err
);
  localparam logic [ATT_W-1:0] TOP = ATT_W'(ATT_MAX);
  logic [ATT_W-1:0] tgt_lim;
  assign tgt_lim = (tgt_att > TOP) ? TOP : tgt_att;

  p_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(chg_en && route_en));

  p_ramp_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && route_en && !done && $past(route_en) && !$past(done))
      |-> ((att == $past(att)) || (att == $past(att) - ATT_W'(1))));

  p_ramp_start_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(route_en) && !done) |-> (att == TOP));

  p_off_r9: assert property (@(posedge clk) disable iff (rst)
    !pwr_req |=> (!chg_en && !route_en && !done && att == TOP));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_err)) |-> cfg_err);

  p_done_route_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (route_en && !chg_en));

  p_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && done && $past(done)) |-> (att == $past(tgt_lim)));
endmodule

bind hp_popfree_seq hp_popfree_seq_chk #(.ATT_W(ATT_W), .ATT_MAX(ATT_MAX)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pwr_req (pwr_req),
  .tgt_att (tgt_att),
  .chg_en  (chg_en),
  .route_en(route_en),
  .att     (att),
  .done    (done),
  .cfg_err (cfg_err)
);

// File: tb/hp_popfree_seq_tb.sv
module hp_popfree_seq_tb;
  localparam int CLK_P = 10;
  localparam int ATT_W = 7;
  localparam int STEP_MS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_req = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_res = 2'b00;
  logic [3:0] cfg_tc_code = 4'd0;
  logic [1:0] cfg_step_code = 2'b00;
  logic [ATT_W-1:0] tgt_att = '0;
  logic ms_tick = 1'b0;
  logic tc8_tick = 1'b0;
  logic chg_en, route_en, done, cfg_err;
  logic [ATT_W-1:0] att;

  int n_run = 0, n_fail = 0, cyc = 0;
  int n_tc = 0, n_ms = 0, ch_cyc = 0, rp_cyc = 0, mono_err = 0;
  logic prev_rt = 1'b0, prev_dn = 1'b0;
  logic [ATT_W-1:0] prev_att = '0;
  int cur_len = 8, cur_step = 1;
  logic exp_err = 1'b0;

  hp_popfree_seq #(.ATT_W(ATT_W), .ATT_MAX(72), .STEP_MS(STEP_MS)) u_dut (
    .clk(clk), .rst(rst), .pwr_req(pwr_req), .cfg_we(cfg_we), .cfg_res(cfg_res),
    .cfg_tc_code(cfg_tc_code), .cfg_step_code(cfg_step_code), .tgt_att(tgt_att),
    .ms_tick(ms_tick), .tc8_tick(tc8_tick), .chg_en(chg_en), .route_en(route_en),
    .att(att), .done(done), .cfg_err(cfg_err));

  always #(CLK_P/2) clk = ~clk;

  function automatic int eighths(input int code);
    int t[16] = '{0, 4, 5, 6, 7, 8, 16, 24, 32, 40, 48, 56, 64, 128, 192, 256};
    return t[code];
  endfunction

  function automatic int interval(input int code);
    return (code == 1) ? STEP_MS : (code == 2) ? 2 * STEP_MS : 4 * STEP_MS;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // tick generators, driven just after the rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      tc8_tick = (cyc % 2 == 0);
      ms_tick  = (cyc % 2 == 1);
      if (cyc > 150000) begin
        check(1'b0, "watchdog", cyc, 150000);
        finish_run();
      end
    end
  end

  // monitor at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (chg_en) ch_cyc++;
      if (chg_en && tc8_tick) n_tc++;
      if (route_en && !done) rp_cyc++;
      if (route_en && !done && ms_tick) n_ms++;
      if (route_en && !done && prev_rt && !prev_dn &&
          !(att == prev_att || att == prev_att - 1)) mono_err++;
      prev_rt = route_en; prev_dn = done; prev_att = att;
    end
  end

  task automatic drv();
    @(posedge clk); #1;
  endtask

  task automatic write_cfg(input int res, input int code, input int step);
    drv();
    cfg_we = 1'b1; cfg_res = 2'(res); cfg_tc_code = 4'(code); cfg_step_code = 2'(step);
    drv();
    cfg_we = 1'b0;
    if (res >= 2 && code >= 13) begin
      cur_len = 64; exp_err = 1'b1;
    end else begin
      cur_len = eighths(code);
    end
    cur_step = step;
  endtask

  task automatic power_up_check(input int tgt, input string tag);
    int tc = (tgt > 72) ? 72 : tgt;
    int guard = 0;
    tgt_att = ATT_W'(tgt);
    n_tc = 0; n_ms = 0; ch_cyc = 0; rp_cyc = 0;
    pwr_req = 1'b1;
    do begin
      @(negedge clk); guard++;
    end while (!done && guard < 6000);
    check(done, {tag, " R7 done"}, done, 1);
    if (cur_len == 0) check(ch_cyc == 1, {tag, " R2 zero-length charge cycles"}, ch_cyc, 1);
    else check(n_tc == cur_len, {tag, " R2 charge ticks"}, n_tc, cur_len);
    if (cur_step == 0) check(rp_cyc == 1, {tag, " R5 disabled ramp cycles"}, rp_cyc, 1);
    else if (tc < 72) check(n_ms == (72 - tc) * interval(cur_step), {tag, " R5 R6 ramp ms ticks"},
                            n_ms, (72 - tc) * interval(cur_step));
    check(int'(att) == tc, {tag, " R6 final attenuation"}, att, tc);
    check(cfg_err == exp_err, {tag, " R4 error flag"}, cfg_err, exp_err);
  endtask

  task automatic power_down_check(input string tag);
    drv();
    pwr_req = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!chg_en && !route_en && !done && att == 72, {tag, " R9 off state"},
          {chg_en, route_en, done}, 0);
  endtask

  initial begin
    int mono0;
    process::self().srandom(32'd1234);
    repeat (3) drv();
    rst = 1'b0;
    @(negedge clk);
    check(!chg_en && !route_en && !done && !cfg_err, "R1 reset flags",
          {chg_en, route_en, done, cfg_err}, 0);
    check(att == 72, "R1 reset attenuation", att, 72);

    // R1 defaults: 8 eighths, step code 01
    drv();
    power_up_check(0, "default");
    // R7 follow after done
    drv(); tgt_att = 7'd20;
    @(posedge clk); @(negedge clk);
    check(att == 20, "R7 follow", att, 20);
    drv(); tgt_att = 7'd100;
    @(posedge clk); @(negedge clk);
    check(att == 72, "R7 R6 follow clamp", att, 72);
    // R8 write while powered is ignored
    drv();
    cfg_we = 1'b1; cfg_res = 2'b00; cfg_tc_code = 4'd12; cfg_step_code = 2'b00;
    drv(); cfg_we = 1'b0;
    power_down_check("cfgwrite");
    power_up_check(10, "R8 after-ignored-write");
    power_down_check("r8");

    // zero length charge, disabled ramp
    write_cfg(0, 0, 0);
    power_up_check(5, "zero");
    power_down_check("zero");
    // long code with small resistor is valid
    write_cfg(1, 13, 1);
    power_up_check(60, "long-valid");
    power_down_check("long-valid");
    // invalid pair: clamp and sticky error
    write_cfg(2, 15, 2);
    power_up_check(70, "R4 clamp");
    power_down_check("clamp");
    write_cfg(0, 3, 3);
    power_up_check(80, "R4 sticky");
    power_down_check("sticky");

    // R9 mid-ramp and mid-charge power-down
    write_cfg(0, 12, 3);
    drv(); tgt_att = '0; pwr_req = 1'b1;
    repeat (20) @(negedge clk);
    check(chg_en, "R9 in charge", chg_en, 1);
    power_down_check("mid-charge");
    drv(); pwr_req = 1'b1;
    do @(negedge clk); while (!route_en);
    repeat (40) @(negedge clk);
    check(route_en && !done, "R9 in ramp", route_en, 1);
    power_down_check("mid-ramp");

    // random runs
    for (int i = 0; i < 10; i++) begin
      write_cfg($urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 3));
      power_up_check($urandom_range(0, 80), "random");
      power_down_check("random");
    end

    mono0 = mono_err;
    check(mono0 == 0, "R6 ramp monotonic single-step", mono0, 0);
    finish_run();
  end
endmodule